// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits beside a CPU bus and watches stores into the cartridge ROM address range (0x0000–0x7FFF). Those stores never reach the ROM. Instead, they load a small set of bank-select registers: a five-bit low ROM bank, a two-bit upper register, a banking-mode bit and a RAM-enable flag.

From that state the block forms three outputs:

- a physical ROM address for the fixed and switchable 16 KiB windows;
- a physical external-RAM address for the 8 KiB RAM window;
- a read-data path that returns 0xFF while external RAM is disabled.

The two-bit upper register is steered by the mode bit. In mode 0 it supplies ROM bank bits 6:5, and the RAM bank stays at 0. In mode 1 it selects the RAM bank, and ROM bank bits 6:5 are zero. A stored low bank of zero is remapped to one. Selected banks beyond the ROM size wrap by masking with the bank count minus one. The bank count is a power-of-two parameter.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with cpu_addr[15:13]=000 and data 0x0A sets the RAM enable. Data 0x00 clears it. Any other data leaves it unchanged.
- R2: A write with cpu_addr[15:13]=001 stores data[4:0] as the low ROM bank, with a value of 0 stored as 1. The upper bank bits are unchanged.
- R3: A write with cpu_addr[15:13]=010 takes data[1:0]. In mode 0 these bits become ROM bank bits 6:5. In mode 1 they become the RAM bank.
- R4: A write with cpu_addr[15:13]=011 sets the mode from data[0]. Setting mode 1 clears ROM bank bits 6:5. Setting mode 0 forces the RAM bank to 0. So in mode 0 the RAM bank is always 0, and in mode 1 ROM bank bits 6:5 are always 0.
- R5: rom_addr_o is {bank, cpu_addr[13:0]} when cpu_addr[14]=1, and {0, cpu_addr[13:0]} when cpu_addr[14]=0. Here bank = {upper, low} after masking.
- R6: The seven-bit selected bank is ANDed with ROM_BANKS-1, so banks past the end of the ROM wrap.
- R7: ram_addr_o is {ram bank, cpu_addr[12:0]}. ext_rdata_o equals ram_rdata_i when RAM is enabled and 0xFF when it is disabled.
- R8: After reset the RAM enable is 0, the low bank is 1, the upper bits are 0, the mode is 0 and the RAM bank is 0.
- R9: A cycle with cpu_wr_i low, or with cpu_addr[15]=1, changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| ram_rdata_i | input | 8 | Data read from the external RAM array |
| rom_addr_o | output | ROM_AW | Physical ROM byte address |
| ram_addr_o | output | 15 | Physical external-RAM byte address |
| ram_bank_o | output | 2 | Selected RAM bank |
| ram_en_o | output | 1 | External RAM enable |
| ext_rdata_o | output | 8 | RAM read data as seen by the CPU |

## Verification
The assertions check, every cycle, the invariants that follow from the register rules:

- the low bank is never zero;
- mode 0 keeps the RAM bank at zero, and mode 1 keeps ROM bits 6:5 at zero;
- the enable codes and the fixed-window address behave as specified;
- ignored cycles leave the state stable.

Only the bench scenarios show the full bank arithmetic. That covers the zero-to-one remap combined with upper bits, wraparound with a smaller ROM, and the RAM bank carried through long random write sequences. The bench compares these against its own model.

// File: rtl/cbc_pkg.sv
// Package: shared widths, register-select codes and constants for the
// cartridge bank controller. Assumes the 16-bit CPU address map with the
// register window in the lower 32 KiB.
package cbc_pkg;
    localparam int LO_W       = 5;   // low ROM bank field
    localparam int HI_W       = 2;   // shared upper / RAM bank field
    localparam int BANK_W     = LO_W + HI_W;
    localparam int RAM_BANK_W = HI_W;
    localparam int WIN_W      = 14;  // 16 KiB ROM window offset
    localparam int RAM_WIN_W  = 13;  // 8 KiB RAM window offset
    localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
    localparam logic [7:0] RAM_OFF_CODE = 8'h00;
    localparam logic [7:0] OPEN_BUS     = 8'hFF;

    // Register selected by cpu_addr[14:13] during a write below 0x8000.
    typedef enum logic [1:0] {
        SEL_RAM_GATE = 2'd0,
        SEL_LOW_BANK = 2'd1,
        SEL_UPPER    = 2'd2,
        SEL_MODE     = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cbc_reg_file.sv
// Module: bank-select register file. Decodes CPU writes to 0x0000-0x7FFF
// into RAM enable, low bank, upper bits, mode and RAM bank. Assumes one
// write per asserted cpu_wr cycle; synchronous active-low reset.
module cbc_reg_file
    import cbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic                  cpu_wr,
    input  logic [7:0]            cpu_wdata,
    output logic                  ram_en,
    output logic [LO_W-1:0]       lo_bank,
    output logic [HI_W-1:0]       hi_bits,
    output logic                  mode,
    output logic [RAM_BANK_W-1:0] ram_bank
);
    reg_sel_e sel;
    logic     wr_hit;

    // Purpose: pick the target register of a write.
    always_comb begin
        sel    = reg_sel_e'(cpu_addr[14:13]);
        wr_hit = cpu_wr && !cpu_addr[15];
    end

    // Purpose: update the bank state from decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_en   <= 1'b0;
            lo_bank  <= LO_W'(1);
            hi_bits  <= '0;
            mode     <= 1'b0;
            ram_bank <= '0;
        end else if (wr_hit) begin
            case (sel)
                SEL_RAM_GATE: begin
                    if (cpu_wdata == RAM_ON_CODE)       ram_en <= 1'b1;
                    else if (cpu_wdata == RAM_OFF_CODE) ram_en <= 1'b0;
                end
                SEL_LOW_BANK: begin
                    lo_bank <= (cpu_wdata[LO_W-1:0] == '0) ? LO_W'(1)
                                                           : cpu_wdata[LO_W-1:0];
                end
                SEL_UPPER: begin
                    if (!mode) hi_bits  <= cpu_wdata[HI_W-1:0];
                    else       ram_bank <= cpu_wdata[RAM_BANK_W-1:0];
                end
                SEL_MODE: begin
                    mode <= cpu_wdata[0];
                    if (cpu_wdata[0]) hi_bits  <= '0;
                    else              ram_bank <= '0;
                end
                default: ;
            endcase
        end
    end

    // R2: a zero low bank never appears
    p_lo_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_bank != '0);
    // R1: enable code turns RAM on
    p_ram_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata == RAM_ON_CODE) |=> ram_en);
    // R4: mode 0 keeps RAM bank at zero
    p_mode0_ram_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (ram_bank == '0));
    // R4: mode 1 keeps upper ROM bits at zero
    p_mode1_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> (hi_bits == '0));
    // R9: no write, no state change
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && !cpu_addr[15]) |=>
        ($stable(ram_en) && $stable(lo_bank) && $stable(hi_bits) &&
         $stable(mode) && $stable(ram_bank)));
    // R2: low-bank write keeps upper bits
    p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b001) |=> $stable(hi_bits));
endmodule

// File: rtl/cbc_addr_map.sv
// Module: combinational address mapper. Forms the physical ROM and RAM
// addresses from the registered bank state and gates RAM read data.
// Assumes ROM_BANKS is a power of two, at least 2.
module cbc_addr_map
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    localparam int ROM_BANK_W = $clog2(ROM_BANKS),
    localparam int ROM_AW     = ROM_BANK_W + WIN_W
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 cpu_addr,
    input  logic [LO_W-1:0]             lo_bank,
    input  logic [HI_W-1:0]             hi_bits,
    input  logic                        ram_en,
    input  logic [RAM_BANK_W-1:0]       ram_bank,
    input  logic [7:0]                  ram_rdata,
    output logic [ROM_AW-1:0]           rom_addr,
    output logic [RAM_BANK_W+RAM_WIN_W-1:0] ram_addr,
    output logic [7:0]                  ext_rdata
);
    localparam int EXT_W = (ROM_BANK_W > BANK_W) ? ROM_BANK_W : BANK_W;
    localparam logic [EXT_W-1:0] WRAP_MASK = EXT_W'(ROM_BANKS - 1);

    logic [EXT_W-1:0]      bank_wide;
    logic [ROM_BANK_W-1:0] rom_bank;

    // Purpose: combine fields, wrap past ROM end, choose fixed or switched window.
    always_comb begin
        bank_wide = EXT_W'({hi_bits, lo_bank}) & WRAP_MASK;
        rom_bank  = cpu_addr[WIN_W] ? bank_wide[ROM_BANK_W-1:0] : '0;
        rom_addr  = {rom_bank, cpu_addr[WIN_W-1:0]};
    end

    // Purpose: RAM address and open-bus read gating.
    always_comb begin
        ram_addr  = {ram_bank, cpu_addr[RAM_WIN_W-1:0]};
        ext_rdata = ram_en ? ram_rdata : OPEN_BUS;
    end

    // R5: fixed window always maps to bank 0
    p_fixed_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[WIN_W] |-> (rom_addr[ROM_AW-1:WIN_W] == '0));
    // R7: disabled RAM reads as open bus
    p_open_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |-> (ext_rdata == OPEN_BUS));
    // R5: offset bits pass through unchanged
    p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]);
endmodule

// File: rtl/cart_bank_ctrl.sv
// Module: cartridge ROM/RAM bank controller top. Connects the register
// file to the address mapper. Assumes the ROM holds ROM_BANKS 16 KiB banks
// (power of two) and external RAM has four 8 KiB banks.
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    localparam int ROM_AW = $clog2(ROM_BANKS) + 14
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr_i,
    input  logic              cpu_wr_i,
    input  logic [7:0]        cpu_wdata_i,
    input  logic [7:0]        ram_rdata_i,
    output logic [ROM_AW-1:0] rom_addr_o,
    output logic [14:0]       ram_addr_o,
    output logic [1:0]        ram_bank_o,
    output logic              ram_en_o,
    output logic [7:0]        ext_rdata_o
);
    logic [LO_W-1:0]       lo_bank;
    logic [HI_W-1:0]       hi_bits;
    logic                  mode;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  ram_en;

    cbc_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr_i),
        .cpu_wr    (cpu_wr_i),
        .cpu_wdata (cpu_wdata_i),
        .ram_en    (ram_en),
        .lo_bank   (lo_bank),
        .hi_bits   (hi_bits),
        .mode      (mode),
        .ram_bank  (ram_bank)
    );

    cbc_addr_map #(.ROM_BANKS(ROM_BANKS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr_i),
        .lo_bank   (lo_bank),
        .hi_bits   (hi_bits),
        .ram_en    (ram_en),
        .ram_bank  (ram_bank),
        .ram_rdata (ram_rdata_i),
        .rom_addr  (rom_addr_o),
        .ram_addr  (ram_addr_o),
        .ext_rdata (ext_rdata_o)
    );

    // Purpose: expose bank and enable state.
    always_comb begin
        ram_bank_o = ram_bank;
        ram_en_o   = ram_en;
    end

    // R4: mode bit not observable at ports except through these invariants
    p_mode_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> (hi_bits == '0));
endmodule

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROM_BANKS  = 64;
    localparam int ROM_AW     = $clog2(ROM_BANKS) + 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic              cpu_wr = 1'b0;
    logic [7:0]        cpu_wdata = '0;
    logic [7:0]        ram_rdata = '0;
    logic [ROM_AW-1:0] rom_addr;
    logic [14:0]       ram_addr;
    logic [1:0]        ram_bank;
    logic              ram_en;
    logic [7:0]        ext_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    bit       m_en;
    bit [4:0] m_lo;
    bit [1:0] m_hi;
    bit       m_mode;
    bit [1:0] m_rb;

    cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr_i(cpu_addr), .cpu_wr_i(cpu_wr),
        .cpu_wdata_i(cpu_wdata), .ram_rdata_i(ram_rdata), .rom_addr_o(rom_addr),
        .ram_addr_o(ram_addr), .ram_bank_o(ram_bank), .ram_en_o(ram_en),
        .ext_rdata_o(ext_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [ROM_AW-1:0] exp_rom(input logic [15:0] a);
        logic [6:0] b;
        b = {m_hi, m_lo} & 7'(ROM_BANKS - 1);
        if (!a[14]) b = '0;
        return {b[ROM_AW-15:0], a[13:0]};
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15]) return;
        case (a[14:13])
            2'd0: if (d == 8'h0A) m_en = 1; else if (d == 8'h00) m_en = 0;
            2'd1: m_lo = (d[4:0] == 0) ? 5'd1 : d[4:0];
            2'd2: if (!m_mode) m_hi = d[1:0]; else m_rb = d[1:0];
            default: begin
                m_mode = d[0];
                if (d[0]) m_hi = 0; else m_rb = 0;
            end
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called just after a negedge; writes on the following posedge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Probe all outputs for a given address, mid low phase.
    task automatic probe(input string req, input logic [15:0] a);
        logic [7:0] rd;
        rd = 8'($urandom);
        cpu_addr = a; ram_rdata = rd;
        #1;
        chk({req, " rom_addr"}, 32'(rom_addr), 32'(exp_rom(a)));
        chk({req, " ram_addr"}, 32'(ram_addr), 32'({m_rb, a[12:0]}));
        chk({req, " ram_bank"}, 32'(ram_bank), 32'(m_rb));
        chk({req, " ram_en"},   32'(ram_en),   32'(m_en));
        chk({req, " ext_rdata"}, 32'(ext_rdata), 32'(m_en ? rd : 8'hFF));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        m_en = 0; m_lo = 1; m_hi = 0; m_mode = 0; m_rb = 0;
        repeat (3) @(negedge clk);
        // R8: reset state
        probe("R8", 16'h4000);
        probe("R8", 16'h7ABC);
        rst_n = 1'b1;
        @(negedge clk);
        probe("R5", 16'h1234);
        // R2: zero stored as one
        wr(16'h2000, 8'h00); probe("R2", 16'h4001);
        wr(16'h3FFF, 8'hE3); probe("R2", 16'h5555);
        // R1: enable, other value ignored, disable
        wr(16'h0000, 8'h0A); probe("R1", 16'hA010);
        wr(16'h1FFF, 8'h05); probe("R1", 16'hA011);
        wr(16'h0100, 8'h00); probe("R1", 16'hB000);
        // R3/R6: upper bits in mode 0; bank 0x63 wraps to 0x23
        wr(16'h4000, 8'hFF); probe("R6", 16'h4321);
        // R2: low write keeps upper bits; bank 0x60 -> 0x61 -> wraps to 0x21
        wr(16'h2000, 8'h20); probe("R2", 16'h7FFF);
        // R4: mode 1 clears upper bits
        wr(16'h6000, 8'h01); probe("R4", 16'h4000);
        // R3: mode 1 routes to RAM bank
        wr(16'h0000, 8'h0A);
        wr(16'h5000, 8'h02); probe("R3", 16'hBFFF);
        // R9: writes at/above 0x8000 ignored
        wr(16'hA000, 8'h00); wr(16'hE000, 8'h01); probe("R9", 16'h6000);
        // R4: mode 0 forces RAM bank 0
        wr(16'h7000, 8'h00); probe("R4", 16'hA123);
        // Random phase
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            if ($urandom_range(0, 3) != 0) a[15] = 1'b0;
            d = ($urandom_range(0, 3) == 0) ? 8'h0A : 8'($urandom);
            if ($urandom_range(0, 7) == 0) d = 8'h00;
            if ($urandom_range(0, 4) == 0) begin
                // R9: no strobe, no change
                cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b0;
                @(negedge clk);
                probe("R9", 16'($urandom));
            end else begin
                wr(a, d);
                probe(m_mode ? "R3" : "R5", 16'($urandom));
            end
        end
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule